// File: doc/BRIEF.md
# Streaming Message Segmenter

The segmenter takes one message at a time and cuts it into data-streaming segments. A message is announced by a request that carries its total byte length (1 to 65536) and a 16-bit stream identifier. The segment size limit is taken from a configuration input at the same moment. The message bytes then arrive on a valid/ready byte port. Each segment leaves on the output port as one descriptor beat followed by its payload bytes. The descriptor beat carries the segment kind, the segment byte count and the stream identifier.

A message that fits within the limit leaves as a single segment. A longer message leaves as a start segment, then zero or more continue segments, then an end segment. Start and continue segments are always full-sized, and only the closing segment may be short. Payload bytes pass straight through combinationally and are never stored. Backpressure on the output therefore reaches the byte input directly. A request with an illegal length or an illegal size limit is refused with an error pulse and produces no output.

Top module: `stream_segmenter`

## Requirements
- R1: After reset, msg_ready_o is 1, and out_valid_o, in_ready_o and err_o are 0.
- R2: A request whose length is 0 or greater than 65536 is refused. err_o is 1 for the one cycle after the request handshake, and no output beat follows. msg_ready_o stays 1. A legal request raises no error.
- R3: A request is refused in the same way as in R2 when max_seg_i lies outside the range 8 to 256.
- R4: A message whose length is at most the sampled limit produces exactly one descriptor. That descriptor has type 2'b00 (single) and a length equal to the message length.
- R5: A longer message produces descriptors in this order: one start (2'b01), zero or more continue (2'b10), and one end (2'b11). Start and continue descriptors have a length equal to the limit. The end descriptor has the length that remains, between 1 and the limit.
- R6: Every descriptor of a message carries, on out_sid_o, the stream identifier given with the request.
- R7: Each descriptor beat (out_desc_o=1) is followed by exactly as many payload beats (out_desc_o=0) as its length. The payload bytes are the input bytes in their input order and unchanged. out_last_o is 1 only on the final byte of a segment.
- R8: msg_ready_o is 0 from the accepted request until the final payload byte of the message is transferred. It is 1 again in the following cycle.
- R9: While a descriptor beat is stalled (out_ready_i=0), it stays valid and its fields stay stable. in_ready_o equals out_ready_i during payload beats and is 0 at all other times.
- R10: max_seg_i is sampled only when a request is accepted. Changing it during a message has no effect on that message's segments.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| max_seg_i | input | 9 | Segment size limit in bytes (8..256), sampled at request |
| msg_valid_i | input | 1 | Message request valid |
| msg_ready_o | output | 1 | Ready for a new message request |
| msg_len_i | input | 17 | Message length in bytes |
| msg_sid_i | input | 16 | Stream identifier |
| err_o | output | 1 | One-cycle refusal pulse |
| in_valid_i | input | 1 | Input byte valid |
| in_ready_o | output | 1 | Input byte accepted |
| in_data_i | input | 8 | Input byte |
| out_valid_o | output | 1 | Output beat valid |
| out_ready_i | input | 1 | Output beat accepted |
| out_desc_o | output | 1 | 1 = descriptor beat, 0 = payload beat |
| out_type_o | output | 2 | Segment kind on descriptor beats |
| out_len_o | output | 9 | Segment byte count on descriptor beats |
| out_sid_o | output | 16 | Stream identifier on descriptor beats |
| out_data_o | output | 8 | Payload byte |
| out_last_o | output | 1 | Final payload byte of the segment |

## Verification
The hardest case to reach is a continue segment whose descriptor stalls on backpressure while the size-limit input is changing underneath it. This needs a message longer than twice the limit and random ready gaps on both byte ports. The bench therefore mixes random messages with small limits, which makes long start/continue/end chains common. It throttles both handshakes and rewrites max_seg_i every cycle of a message. Directed lengths at exact multiples of the limit, one byte past them, and the full 65536-byte message cover the boundaries.

// File: rtl/stream_seg_pkg.sv
package stream_seg_pkg;
  typedef enum logic [1:0] {
    SEG_SINGLE = 2'b00,
    SEG_START  = 2'b01,
    SEG_CONT   = 2'b10,
    SEG_END    = 2'b11
  } seg_type_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DESC,
    ST_PAY
  } seg_state_e;
endpackage

// File: rtl/stream_seg_plan.sv
module stream_seg_plan
  import stream_seg_pkg::*;
#(
  parameter int LEN_W = 17,
  parameter int SEG_W = 9
) (
  input  logic [LEN_W-1:0] rem_i,
  input  logic             first_i,
  input  logic [SEG_W-1:0] max_i,
  output seg_type_e        type_o,
  output logic [SEG_W-1:0] len_o
);
  logic [LEN_W-1:0] max_ext;
  logic             fits;

  assign max_ext = {{(LEN_W-SEG_W){1'b0}}, max_i};
  assign fits    = rem_i <= max_ext;
  // remainder fits in SEG_W whenever it is below the limit
  assign len_o   = fits ? rem_i[SEG_W-1:0] : max_i;

  always_comb begin
    if (first_i) type_o = fits ? SEG_SINGLE : SEG_START;
    else         type_o = fits ? SEG_END    : SEG_CONT;
  end
endmodule

// File: rtl/stream_seg_cnt.sv
module stream_seg_cnt #(
  parameter int W = 17
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic [W-1:0] cnt_o,
  output logic         last_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (dec_i)  cnt_q <= cnt_q - W'(1);
  end

  assign cnt_o  = cnt_q;
  assign last_o = cnt_q == W'(1);

  // R7
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> cnt_q != '0);
endmodule

// File: rtl/stream_segmenter.sv
module stream_segmenter
  import stream_seg_pkg::*;
#(
  parameter int MAX_MSG_BYTES = 65536,
  parameter int SEG_MIN       = 8,
  parameter int SEG_MAX       = 256,
  parameter int SID_W         = 16,
  parameter int DATA_W        = 8,
  localparam int LEN_W        = $clog2(MAX_MSG_BYTES + 1),
  localparam int SEG_W        = $clog2(SEG_MAX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SEG_W-1:0]  max_seg_i,
  input  logic              msg_valid_i,
  output logic              msg_ready_o,
  input  logic [LEN_W-1:0]  msg_len_i,
  input  logic [SID_W-1:0]  msg_sid_i,
  output logic              err_o,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic              out_desc_o,
  output logic [1:0]        out_type_o,
  output logic [SEG_W-1:0]  out_len_o,
  output logic [SID_W-1:0]  out_sid_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_last_o
);
  seg_state_e       state_q, state_d;
  logic [SEG_W-1:0] max_q;
  logic [SID_W-1:0] sid_q;
  logic             first_q;
  logic             err_q;

  logic             msg_ok, msg_fire, accept, desc_fire, byte_fire;
  logic [LEN_W-1:0] rem_cnt;
  logic             rem_last;
  logic [SEG_W-1:0] seg_cnt;
  logic             seg_last;
  seg_type_e        plan_type;
  logic [SEG_W-1:0] plan_len;

  assign msg_ok = (msg_len_i != '0) && (msg_len_i <= LEN_W'(MAX_MSG_BYTES)) &&
                  (max_seg_i >= SEG_W'(SEG_MIN)) && (max_seg_i <= SEG_W'(SEG_MAX));
  assign msg_ready_o = state_q == ST_IDLE;
  assign msg_fire    = msg_valid_i && msg_ready_o;
  assign accept      = msg_fire && msg_ok;
  assign desc_fire   = (state_q == ST_DESC) && out_ready_i;
  assign byte_fire   = (state_q == ST_PAY) && in_valid_i && out_ready_i;

  stream_seg_cnt #(.W(LEN_W)) u_rem_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .load_val_i (msg_len_i),
    .dec_i      (byte_fire),
    .cnt_o      (rem_cnt),
    .last_o     (rem_last)
  );

  stream_seg_cnt #(.W(SEG_W)) u_seg_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (desc_fire),
    .load_val_i (plan_len),
    .dec_i      (byte_fire),
    .cnt_o      (seg_cnt),
    .last_o     (seg_last)
  );

  stream_seg_plan #(.LEN_W(LEN_W), .SEG_W(SEG_W)) u_plan (
    .rem_i   (rem_cnt),
    .first_i (first_q),
    .max_i   (max_q),
    .type_o  (plan_type),
    .len_o   (plan_len)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept)    state_d = ST_DESC;
      ST_DESC: if (desc_fire) state_d = ST_PAY;
      ST_PAY:  if (byte_fire && seg_last) state_d = rem_last ? ST_IDLE : ST_DESC;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      max_q   <= '0;
      sid_q   <= '0;
      first_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= msg_fire && !msg_ok;
      if (accept) begin
        max_q   <= max_seg_i;
        sid_q   <= msg_sid_i;
        first_q <= 1'b1;
      end else if (desc_fire) begin
        first_q <= 1'b0;
      end
    end
  end

  assign err_o       = err_q;
  assign out_valid_o = (state_q == ST_DESC) || ((state_q == ST_PAY) && in_valid_i);
  assign out_desc_o  = state_q == ST_DESC;
  assign out_type_o  = plan_type;
  assign out_len_o   = plan_len;
  assign out_sid_o   = sid_q;
  assign out_data_o  = in_data_i;
  assign out_last_o  = (state_q == ST_PAY) && seg_last;
  assign in_ready_o  = (state_q == ST_PAY) && out_ready_i;

  // R2
  reject_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> msg_ready_o && !out_valid_o);

  // R5
  full_seg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_desc_o && (out_type_o == SEG_START || out_type_o == SEG_CONT))
      |-> out_len_o == max_q);

  // R5
  seg_len_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_desc_o) |-> (out_len_o != '0) && (out_len_o <= max_q));

  // R8
  msg_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i && out_last_o && rem_last) |=> msg_ready_o);

  // R9
  desc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_desc_o && !out_ready_i) |=>
      (out_valid_o && out_desc_o && $stable(out_type_o) && $stable(out_len_o) &&
       $stable(out_sid_o)));
endmodule

// File: tb/stream_segmenter_bench.sv
module stream_segmenter_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [8:0]  max_seg_i = '0;
  logic        msg_valid_i = 1'b0;
  logic        msg_ready_o;
  logic [16:0] msg_len_i = '0;
  logic [15:0] msg_sid_i = '0;
  logic        err_o;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [7:0]  in_data_i = '0;
  logic        out_valid_o;
  logic        out_ready_i = 1'b0;
  logic        out_desc_o;
  logic [1:0]  out_type_o;
  logic [8:0]  out_len_o;
  logic [15:0] out_sid_o;
  logic [7:0]  out_data_o;
  logic        out_last_o;

  int checks = 0;
  int errors = 0;

  always #5 clk_i = ~clk_i;

  stream_segmenter u_stream_segmenter (
    .clk_i, .rst_ni, .max_seg_i, .msg_valid_i, .msg_ready_o, .msg_len_i,
    .msg_sid_i, .err_o, .in_valid_i, .in_ready_o, .in_data_i, .out_valid_o,
    .out_ready_i, .out_desc_o, .out_type_o, .out_len_o, .out_sid_o,
    .out_data_o, .out_last_o
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_of(input int sid, input int idx);
    return 8'(idx * 7 + sid + (idx >> 8));
  endfunction

  task automatic reject(input int len, input int mx, input string req);
    @(negedge clk_i);
    msg_valid_i = 1'b1; msg_len_i = 17'(len); max_seg_i = 9'(mx); msg_sid_i = 16'h0bad;
    @(posedge clk_i);
    @(negedge clk_i);
    msg_valid_i = 1'b0;
    #1;
    chk(err_o == 1'b1, req, "err pulse", int'(err_o), 1);
    chk(out_valid_o == 1'b0, req, "no output on reject", int'(out_valid_o), 0);
    @(negedge clk_i);
    chk(err_o == 1'b0, req, "err one cycle", int'(err_o), 0);
    chk(msg_ready_o == 1'b1 && out_valid_o == 1'b0, req, "idle after reject",
        int'(msg_ready_o), 1);
  endtask

  task automatic run_msg(input int len, input int sid, input int mx, input bit dense);
    int  pi = 0, ci = 0, rem = len, seg_left = 0;
    bit  first = 1'b1, busy_ok = 1'b1, stall = 1'b0;
    logic [1:0]  s_type;
    logic [8:0]  s_len;
    logic [15:0] s_sid;
    int exp_len, exp_type;
    @(negedge clk_i);
    msg_valid_i = 1'b1; msg_len_i = 17'(len); msg_sid_i = 16'(sid); max_seg_i = 9'(mx);
    #1;
    chk(msg_ready_o == 1'b1, "R8", "ready before request", int'(msg_ready_o), 1);
    @(posedge clk_i);
    @(negedge clk_i);
    msg_valid_i = 1'b0;
    chk(err_o == 1'b0, "R2", "no err on legal request", int'(err_o), 0);
    while (ci < len) begin
      max_seg_i   = 9'($urandom);  // R10: scrambled during the message
      in_valid_i  = (pi < len) && (dense || ($urandom % 4 != 0));
      in_data_i   = byte_of(sid, pi);
      out_ready_i = dense || ($urandom % 4 != 0);
      #1;
      if (msg_ready_o) busy_ok = 1'b0;
      chk(in_ready_o == ((seg_left > 0) && out_ready_i), "R9", "in_ready",
          int'(in_ready_o), int'((seg_left > 0) && out_ready_i));
      if (stall)
        chk(out_valid_o && out_desc_o && out_type_o == s_type && out_len_o == s_len &&
            out_sid_o == s_sid, "R9", "stalled descriptor held", int'(out_len_o), int'(s_len));
      stall = 1'b0;
      if (out_valid_o && out_desc_o) begin
        chk(seg_left == 0, "R7", "descriptor inside payload", seg_left, 0);
        if (out_ready_i) begin
          exp_len  = (rem <= mx) ? rem : mx;
          exp_type = first ? ((rem <= mx) ? 0 : 1) : ((rem <= mx) ? 3 : 2);
          chk(int'(out_type_o) == exp_type, (exp_type == 0) ? "R4" : "R5", "segment type",
              int'(out_type_o), exp_type);
          chk(int'(out_len_o) == exp_len, (exp_type == 0) ? "R4" : "R5", "segment length",
              int'(out_len_o), exp_len);
          chk(int'(out_sid_o) == sid, "R6", "stream id", int'(out_sid_o), sid);
          seg_left = exp_len;
          first = 1'b0;
        end else begin
          stall = 1'b1; s_type = out_type_o; s_len = out_len_o; s_sid = out_sid_o;
        end
      end else if (out_valid_o && out_ready_i) begin
        chk(seg_left > 0, "R7", "payload without descriptor", seg_left, 1);
        chk(out_data_o == byte_of(sid, ci), "R7", "payload byte", int'(out_data_o),
            int'(byte_of(sid, ci)));
        chk(out_last_o == (seg_left == 1), "R7", "last flag", int'(out_last_o),
            int'(seg_left == 1));
        seg_left--; ci++; rem--;
      end
      if (in_valid_i && in_ready_o) pi++;
      @(negedge clk_i);
    end
    in_valid_i = 1'b0; out_ready_i = 1'b0;
    #1;
    chk(busy_ok, "R8", "ready low while busy", int'(busy_ok), 1);
    chk(msg_ready_o == 1'b1 && out_valid_o == 1'b0, "R8", "ready after message",
        int'(msg_ready_o), 1);
    chk(seg_left == 0, "R7", "segment complete", seg_left, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1723));
    #2;
    chk(msg_ready_o == 1'b1, "R1", "msg_ready in reset", int'(msg_ready_o), 1);
    chk(out_valid_o == 1'b0 && in_ready_o == 1'b0, "R1", "quiet in reset",
        int'(out_valid_o), 0);
    chk(err_o == 1'b0, "R1", "err in reset", int'(err_o), 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(msg_ready_o == 1'b1 && out_valid_o == 1'b0 && err_o == 1'b0, "R1",
        "idle after reset", int'(out_valid_o), 0);

    reject(0, 64, "R2");
    reject(65537, 64, "R2");
    reject(100, 7, "R3");
    reject(100, 257, "R3");
    reject(100, 0, "R3");

    run_msg(1, 16'h1111, 8, 1'b0);
    run_msg(8, 16'h2222, 8, 1'b0);
    run_msg(9, 16'h3333, 8, 1'b0);
    run_msg(16, 16'h4444, 8, 1'b0);
    run_msg(17, 16'h5555, 8, 1'b0);
    run_msg(256, 16'h6666, 256, 1'b0);
    run_msg(257, 16'h7777, 256, 1'b0);
    run_msg(3, 16'h8888, 200, 1'b1);
    run_msg(65536, 16'hffff, 256, 1'b1);
    for (int k = 0; k < 25; k++)
      run_msg(1 + int'($urandom % 1500), int'($urandom % 65536),
              8 + int'($urandom % 249), 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule